// File: doc/BRIEF.md
# Runtime-Programmable Two-Plane Logic Array

This block is a small programmable logic array that serves as a local control engine. Its whole function can be rewritten while the chip runs. The first plane holds sixteen product terms. Each term stores, for every one of six inputs, a ternary code: the term can require the input to be 0 or 1, ignore it, or never match at all. The second plane is plain writable storage. For each of the four outputs it holds one enable bit per product term, and each output is the OR of the active terms whose bits are set.

A configuration port loads one product-term row or one output column per clock. An evaluation port samples a 6-bit input vector when `eval_en` is high and presents the 4-bit result one clock later, together with a valid flag. After reset every term is disabled and every column is empty, so the array evaluates to zero until it is programmed.

Top module: `pla_engine`

## Requirements
- R1: During reset (`rst_n` low, sampled at a clock edge), `out_q` and `out_vld` are cleared, every product term is set to never-match and every output column is cleared. Any evaluation before programming therefore returns 0.
- R2: A product-term row holds bits [2i+1:2i] for input i. Bit 2i+1 means "accept a 1" and bit 2i means "accept a 0". The code 2'b10 matches only a 1, 2'b01 matches only a 0, 2'b11 matches either, and 2'b00 matches neither. A term is active when every input is accepted.
- R3: A term whose row is all 2'b11 codes is active for every input vector.
- R4: A term with a 2'b00 code for any input is never active, whatever the other codes and inputs are.
- R5: Output o is the OR of the active terms t for which bit t of column o is 1. An output whose column is all zero reads 0.
- R6: When `eval_en` is sampled high, `out_q` shows the result for the sampled `eval_in` one clock later and `out_vld` is 1. When `eval_en` is sampled low, `out_q` holds its value and `out_vld` is 0.
- R7: A configuration write (`cfg_we` = 1) with `cfg_sel` = 0 loads `cfg_data[11:0]` into term `cfg_addr`. With `cfg_sel` = 1 it loads `cfg_data[15:0]` into column `cfg_addr`. An evaluation sampled in the same cycle as the write uses the old contents. Evaluations from the next cycle on use the new contents.
- R8: A column write with `cfg_addr` of 4 or more changes no output column, so later results are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Write target: 0 = product-term row, 1 = output column |
| cfg_addr | input | 4 | Index of the term or the column |
| cfg_data | input | 16 | Row (low 12 bits) or column (16 bits) contents |
| eval_en | input | 1 | Sample `eval_in` this cycle |
| eval_in | input | 6 | Input vector to evaluate |
| out_q | output | 4 | Registered output vector |
| out_vld | output | 1 | `out_q` was updated by the previous sample |

## Verification
Three kinds of term are tried. An all-don't-care term shows that an unconstrained term fires. A term with one never-match code shows that a single 00 code disables the whole term. An exact-match term is evaluated on its own vector and on a vector one bit away, which tells a working ternary compare apart from one that ignores inputs. Writes are issued in the same cycle as evaluations, which shows that old contents are used for that cycle. Out-of-range column writes must leave results unchanged. Random programming with biased codes, so that terms actually hit, then mixes overlapping terms in shared columns, where the OR combining and the column selection are checked against a model.

// File: rtl/pla_pkg.sv
package pla_pkg;
  typedef enum logic { CFG_TERM = 1'b0, CFG_COL = 1'b1 } cfg_target_e;
  typedef enum logic [1:0] {
    TC_NEVER = 2'b00,
    TC_ZERO  = 2'b01,
    TC_ONE   = 2'b10,
    TC_ANY   = 2'b11
  } tern_code_e;
endpackage

// File: rtl/pla_cfg_decode.sv
module pla_cfg_decode
  import pla_pkg::*;
(
  input  logic cfg_we,
  input  logic cfg_sel,
  output logic term_we,
  output logic col_we
);
  cfg_target_e tgt;
  always_comb begin
    tgt     = cfg_target_e'(cfg_sel);
    term_we = cfg_we && (tgt == CFG_TERM);
    col_we  = cfg_we && (tgt == CFG_COL);
  end
endmodule

// File: rtl/pla_term_plane.sv
module pla_term_plane #(
  parameter int N_IN   = 6,
  parameter int N_TERM = 16,
  parameter int AW     = 4,
  localparam int RW    = 2 * N_IN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [RW-1:0]     wr_row,
  input  logic [N_IN-1:0]   in_vec,
  output logic [N_TERM-1:0] term_hit
);
  // One ternary compare: each input picks the accept bit for its value.
  function automatic logic ternary_match(input logic [RW-1:0] row,
                                         input logic [N_IN-1:0] x);
    logic m;
    m = 1'b1;
    for (int i = 0; i < N_IN; i++) begin
      m = m & (x[i] ? row[2*i+1] : row[2*i]);
    end
    return m;
  endfunction

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [RW-1:0] row_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        row_q <= '0;
      end else if (wr_en && (wr_addr == AW'(t))) begin
        row_q <= wr_row;
      end
    end
    assign term_hit[t] = ternary_match(row_q, in_vec);
  end
endmodule

// File: rtl/pla_sum_plane.sv
module pla_sum_plane #(
  parameter int N_TERM = 16,
  parameter int N_OUT  = 4,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [N_TERM-1:0] wr_col,
  input  logic [N_TERM-1:0] term_hit,
  output logic [N_OUT-1:0]  or_comb,
  output logic [N_OUT-1:0]  col_any
);
  function automatic logic column_or(input logic [N_TERM-1:0] col,
                                     input logic [N_TERM-1:0] hit);
    return |(col & hit);
  endfunction

  for (genvar o = 0; o < N_OUT; o++) begin : g_col
    logic [N_TERM-1:0] col_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        col_q <= '0;
      end else if (wr_en && (wr_addr == AW'(o))) begin
        col_q <= wr_col;
      end
    end
    assign or_comb[o] = column_or(col_q, term_hit);
    assign col_any[o] = |col_q;
  end
endmodule

// File: rtl/pla_engine.sv
module pla_engine #(
  parameter int N_IN   = 6,
  parameter int N_OUT  = 4,
  parameter int N_TERM = 16,
  localparam int AW    = $clog2((N_TERM > N_OUT) ? N_TERM : N_OUT),
  localparam int RW    = 2 * N_IN,
  localparam int DW    = (N_TERM > RW) ? N_TERM : RW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [DW-1:0]    cfg_data,
  input  logic             eval_en,
  input  logic [N_IN-1:0]  eval_in,
  output logic [N_OUT-1:0] out_q,
  output logic             out_vld
);
  logic              term_we;
  logic              col_we;
  logic [N_TERM-1:0] term_hit;
  logic [N_OUT-1:0]  or_comb;
  logic [N_OUT-1:0]  col_any;

  pla_cfg_decode u_dec (
    .cfg_we (cfg_we),
    .cfg_sel(cfg_sel),
    .term_we(term_we),
    .col_we (col_we)
  );

  pla_term_plane #(.N_IN(N_IN), .N_TERM(N_TERM), .AW(AW)) u_terms (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (term_we),
    .wr_addr (cfg_addr),
    .wr_row  (cfg_data[RW-1:0]),
    .in_vec  (eval_in),
    .term_hit(term_hit)
  );

  pla_sum_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT), .AW(AW)) u_sums (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (col_we),
    .wr_addr (cfg_addr),
    .wr_col  (cfg_data[N_TERM-1:0]),
    .term_hit(term_hit),
    .or_comb (or_comb),
    .col_any (col_any)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q   <= '0;
      out_vld <= 1'b0;
    end else begin
      out_vld <= eval_en;
      if (eval_en) out_q <= or_comb;
    end
  end
endmodule

// File: rtl/pla_engine_chk.sv
module pla_engine_chk #(
  parameter int N_OUT  = 4,
  parameter int N_TERM = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              eval_en,
  input logic [N_OUT-1:0]  out_q,
  input logic              out_vld,
  input logic [N_OUT-1:0]  or_comb,
  input logic [N_OUT-1:0]  col_any,
  input logic [N_TERM-1:0] term_hit
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    !rst_n |=> (out_q == '0) && !out_vld);

  assert_reset_disables_terms_R1: assert property (@(posedge clk)
    !rst_n |=> (term_hit == '0));

  assert_empty_column_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (or_comb & ~col_any) == '0);

  assert_result_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eval_en |=> out_vld && (out_q == $past(or_comb)));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_en |=> !out_vld && $stable(out_q));
endmodule

bind pla_engine pla_engine_chk #(.N_OUT(N_OUT), .N_TERM(N_TERM)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .eval_en (eval_en),
  .out_q   (out_q),
  .out_vld (out_vld),
  .or_comb (or_comb),
  .col_any (col_any),
  .term_hit(term_hit)
);

// File: tb/pla_engine_tb.sv
module pla_engine_tb;
  localparam int NI = 6;
  localparam int NO = 4;
  localparam int NT = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_data = '0;
  logic        eval_en = 1'b0;
  logic [5:0]  eval_in = '0;
  logic [3:0]  out_q;
  logic        out_vld;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [11:0] row_m [NT];
  logic [15:0] col_m [NO];
  logic [3:0]  prev_out;

  always #10 clk = ~clk;

  pla_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .eval_en(eval_en),
    .eval_in(eval_in), .out_q(out_q), .out_vld(out_vld)
  );

  // Model: a term is live when each input's code is "either" or names its value.
  function automatic logic [3:0] model_eval(input logic [5:0] x);
    logic [3:0] r;
    r = '0;
    for (int t = 0; t < NT; t++) begin
      bit live;
      live = 1'b1;
      for (int i = 0; i < NI; i++) begin
        logic [1:0] c;
        c = row_m[t][2*i +: 2];
        if (!(c == 2'b11 || c == (x[i] ? 2'b10 : 2'b01))) live = 1'b0;
      end
      for (int o = 0; o < NO; o++) begin
        if (live && col_m[o][t]) r[o] = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic logic [11:0] exact_row(input logic [5:0] x);
    logic [11:0] r;
    for (int i = 0; i < NI; i++) r[2*i +: 2] = x[i] ? 2'b10 : 2'b01;
    return r;
  endfunction

  function automatic logic [11:0] rand_row();
    logic [11:0] r;
    for (int i = 0; i < NI; i++) begin
      int k;
      k = $urandom % 10;
      r[2*i +: 2] = (k == 0) ? 2'b00 : (k < 3) ? 2'b01 : (k < 5) ? 2'b10 : 2'b11;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {vld,out} actual %b expected %b", tag, act, exp);
    end
  endtask

  // Called just after a falling edge; drives one cycle and checks the result.
  task automatic step(input string tag, input bit we, input bit sel,
                      input logic [3:0] addr, input logic [15:0] data,
                      input bit en, input logic [5:0] x);
    logic [3:0] exp;
    cfg_we = we; cfg_sel = sel; cfg_addr = addr; cfg_data = data;
    eval_en = en; eval_in = x;
    exp = en ? model_eval(x) : prev_out;
    if (we && !sel) row_m[addr] = data[11:0];
    if (we && sel && addr < NO) col_m[addr[1:0]] = data;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    check(tag, {out_vld, out_q}, {en, exp});
    prev_out = exp;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20241));
    for (int t = 0; t < NT; t++) row_m[t] = '0;
    for (int o = 0; o < NO; o++) col_m[o] = '0;
    prev_out = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset outputs", {out_vld, out_q}, 5'b0);
    rst_n = 1'b1;
    step("R1 idle after reset", 0, 0, 0, 0, 0, 6'h00);
    step("R1 unprogrammed eval", 0, 0, 0, 0, 1, 6'h3F);
    step("R1 unprogrammed eval", 0, 0, 0, 0, 1, 6'h00);
    // R7: write and evaluate in the same cycle -> old contents used
    step("R7 row write same cycle", 1, 0, 4'd0, 16'h0FFF, 1, 6'h00);
    step("R7 col write same cycle", 1, 1, 4'd0, 16'h0001, 1, 6'h2A);
    step("R3 all-either term", 0, 0, 0, 0, 1, 6'h15);
    step("R3 all-either term", 0, 0, 0, 0, 1, 6'h3F);
    // R4: one never code disables the term
    step("R4 setup row", 1, 0, 4'd1, 16'h0FCF, 0, 6'h00);
    step("R4 setup col", 1, 1, 4'd1, 16'h0002, 0, 6'h00);
    step("R4 never code", 0, 0, 0, 0, 1, 6'h00);
    step("R4 never code", 0, 0, 0, 0, 1, 6'h3F);
    step("R4 never code", 0, 0, 0, 0, 1, 6'h04);
    // R2: exact match on one vector
    step("R2 setup row", 1, 0, 4'd2, {4'h0, exact_row(6'h2C)}, 0, 6'h00);
    step("R2 setup col", 1, 1, 4'd2, 16'h0004, 0, 6'h00);
    step("R2 exact hit", 0, 0, 0, 0, 1, 6'h2C);
    step("R2 one bit off", 0, 0, 0, 0, 1, 6'h2D);
    step("R2 one bit off", 0, 0, 0, 0, 1, 6'h0C);
    // R5: empty column and shared column
    step("R5 empty column", 0, 0, 0, 0, 1, 6'h2C);
    step("R5 setup shared", 1, 1, 4'd3, 16'h0006, 1, 6'h2C);
    step("R5 shared column", 0, 0, 0, 0, 1, 6'h2C);
    step("R5 shared column", 0, 0, 0, 0, 1, 6'h11);
    // R6: hold while idle
    step("R6 idle hold", 0, 0, 0, 0, 0, 6'h11);
    step("R6 idle hold", 0, 0, 0, 0, 0, 6'h2C);
    // R8: out-of-range column address
    step("R8 bad column write", 1, 1, 4'd9, 16'hFFFF, 1, 6'h2C);
    step("R8 bad column write", 1, 1, 4'd4, 16'hFFFF, 0, 6'h00);
    step("R8 after bad write", 0, 0, 0, 0, 1, 6'h11);
    step("R8 after bad write", 0, 0, 0, 0, 1, 6'h2C);
    // Random mix, checked against the model (R5, R7)
    for (int n = 0; n < 600; n++) begin
      bit we, sel, en;
      logic [3:0] a;
      logic [15:0] d;
      we  = ($urandom % 3) == 0;
      sel = $urandom % 2;
      en  = ($urandom % 4) != 0;
      a   = sel ? 4'($urandom % 6) : 4'($urandom % 16);
      d   = sel ? 16'($urandom) : {4'($urandom), rand_row()};
      step("R5 random", we, sel, a, d, en, 6'($urandom));
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule